// File: doc/BRIEF.md
# Polyphase Wavelet Analysis Filter Bank

This block computes one analysis level of a one-dimensional discrete wavelet transform by direct convolution. It takes a stream of signed samples, one per clock at most. It returns two decimated coefficient streams on a single output port: approximation (low-pass) and detail (high-pass). A band bit tags each output word. The low-pass taps are fixed at elaboration. The high-pass taps are the quadrature mirror of the low-pass taps. Each filter is split into an even-tap branch and an odd-tap branch, and the two branches work in parallel. A full sample pair is therefore consumed in one step. With input arriving every clock, the output port carries a coefficient on every clock.

A stream may have any length. The design has no notion of length until the user pulses `flush`. On a flush, the block feeds zeros through the same datapath until every coefficient that touches a real sample has been produced. It then clears its history, so the next stream starts as if from reset.

Top module: `dwt_analysis_bank`

## Requirements
- R1: After reset, out_valid, out_data and out_band are all 0.
- R2: Number the accepted samples of a stream x[0], x[1], ..., and treat indices below 0 as zero. For pair k, the low-pass word is sat(round(sum over j of h[j]*x[2k+1-j])) with j = 0..TAPS-1. It is emitted with out_band = 0. The default taps, Q1.15 with h[0] first, are 15826, 27411, 7345, -4240.
- R3: For pair k, the high-pass word uses the same formula with g[j] = (-1)^j * h[TAPS-1-j]. It is emitted with out_band = 1.
- R4: Every pair yields its low-pass word, and on the very next cycle its high-pass word.
- R5: The low-pass word is on the output 3 clock edges after the edge that accepts the pair's odd sample x[2k+1]. The high-pass word follows one edge later.
- R6: When samples are accepted on consecutive clocks, out_valid is high on every cycle in steady state, and no two pairs complete on adjacent edges.
- R7: Rounding adds 2^14 to the full-precision sum and then shifts it right arithmetically by 15. The result saturates to the range -32768..32767.
- R8: A one-cycle flush pulse first injects one zero if an odd sample is pending, then injects TAPS-2 more zeros. The output sequence then ends at the last pair of the zero-padded convolution. After that, the history is cleared, so the next stream's results do not depend on the previous stream.
- R9: While flush zeros are being injected, in_valid is ignored and the sample on in_data is dropped.
- R10: Idle cycles between accepted samples do not change any coefficient value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample on in_data is accepted this cycle |
| in_data | input | DW | Signed input sample |
| flush | input | 1 | One-cycle request to zero-pad and end the current stream |
| out_valid | output | 1 | out_data holds a coefficient |
| out_data | output | DW | Signed rounded coefficient |
| out_band | output | 1 | 0 for low-pass, 1 for high-pass |

## Verification
Suppose the pair-collection state goes wrong, for example the pending even sample is lost or the windows shift by the wrong amount. Every later coefficient would then be off from the first affected pair onward, and the fault shows 3 edges after that pair's odd sample. A corrupted hold register in the band sequencer shows up as a bad high-pass word one cycle after the correct low-pass word. It can also show as a broken low/high alternation, which the bound properties catch on the same edge. Two failures only appear after a flush: faults in zero injection, and history that is not cleared. Either one shows as a missing final pair or a wrong first pair of the next stream.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

    typedef enum logic {
        BAND_LO = 1'b0,
        BAND_HI = 1'b1
    } band_e;

endpackage

// File: rtl/dwt_pair_front.sv
module dwt_pair_front #(
    parameter int DW   = 16,
    parameter int TAPS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DW-1:0]     in_data,
    input  logic                     flush,
    output logic                     pair_valid,
    output logic [TAPS/2-1:0][DW-1:0] even_win,
    output logic [TAPS/2-1:0][DW-1:0] odd_win
);
    localparam int HALF  = TAPS / 2;
    localparam int PAD   = TAPS - 2;
    localparam int CNT_W = (TAPS > 2) ? $clog2(TAPS) : 1;

    typedef struct packed {
        logic                      have_even;
        logic [DW-1:0]             even_hold;
        logic [HALF-1:0][DW-1:0]   even_win;
        logic [HALF-1:0][DW-1:0]   odd_win;
        logic                      pair_valid;
        logic [CNT_W-1:0]          zeros_left;
        logic                      clear_hist;
    } front_t;

    front_t st_q, st_d;

    always_comb begin
        logic          take;
        logic [DW-1:0] smp;
        logic [CNT_W-1:0] pad_cnt;
        st_d            = st_q;
        st_d.pair_valid = 1'b0;
        st_d.clear_hist = 1'b0;
        take            = 1'b0;
        smp             = '0;
        pad_cnt         = CNT_W'(PAD) + CNT_W'(st_q.have_even);

        if (st_q.clear_hist) begin
            st_d.even_win = '0;
            st_d.odd_win  = '0;
        end

        if (st_q.zeros_left != '0) begin
            take            = 1'b1;
            st_d.zeros_left = st_q.zeros_left - 1'b1;
            if (st_q.zeros_left == CNT_W'(1)) begin
                st_d.clear_hist = 1'b1;
            end
        end else if (flush) begin
            st_d.zeros_left = pad_cnt;
            if (pad_cnt == '0) begin
                st_d.clear_hist = 1'b1;
            end
        end else if (in_valid) begin
            take = 1'b1;
            smp  = in_data;
        end

        if (take) begin
            if (!st_q.have_even) begin
                st_d.have_even = 1'b1;
                st_d.even_hold = smp;
            end else begin
                st_d.have_even   = 1'b0;
                st_d.pair_valid  = 1'b1;
                st_d.even_win[0] = st_q.even_hold;
                st_d.odd_win[0]  = smp;
                for (int i = 1; i < HALF; i++) begin
                    st_d.even_win[i] = st_q.even_win[i-1];
                    st_d.odd_win[i]  = st_q.odd_win[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_valid = st_q.pair_valid;
    assign even_win   = st_q.even_win;
    assign odd_win    = st_q.odd_win;

endmodule

// File: rtl/dwt_polyphase_mac.sv
module dwt_polyphase_mac #(
    parameter int               DW    = 16,
    parameter int               CW    = 16,
    parameter int               TAPS  = 4,
    parameter logic [TAPS*CW-1:0] COEF = '0,
    parameter bit               HIGH  = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pair_valid,
    input  logic [TAPS/2-1:0][DW-1:0] even_win,
    input  logic [TAPS/2-1:0][DW-1:0] odd_win,
    output logic                      res_valid,
    output logic signed [DW-1:0]      res_data
);
    localparam int HALF  = TAPS / 2;
    localparam int ACC_W = DW + CW + $clog2(TAPS);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (DW-1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(2 ** (CW-2));

    logic signed [CW-1:0] tap [TAPS];

    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        localparam int SRC = HIGH ? (TAPS - 1 - j) : j;
        localparam logic signed [CW-1:0] RAW = COEF[SRC*CW +: CW];
        if (HIGH && (j % 2 == 1)) begin : g_neg
            assign tap[j] = -RAW;
        end else begin : g_pos
            assign tap[j] = RAW;
        end
    end

    typedef struct packed {
        logic                    s1_valid;
        logic signed [ACC_W-1:0] br_even;
        logic signed [ACC_W-1:0] br_odd;
        logic                    s2_valid;
        logic signed [DW-1:0]    result;
    } mac_t;

    mac_t st_q, st_d;

    always_comb begin
        logic signed [ACC_W-1:0] acc_e, acc_o, sum, rnd;
        st_d  = st_q;
        acc_e = '0;
        acc_o = '0;
        for (int i = 0; i < HALF; i++) begin
            acc_e = acc_e + ACC_W'(tap[2*i])   * ACC_W'($signed(odd_win[i]));
            acc_o = acc_o + ACC_W'(tap[2*i+1]) * ACC_W'($signed(even_win[i]));
        end
        st_d.s1_valid = pair_valid;
        if (pair_valid) begin
            st_d.br_even = acc_e;
            st_d.br_odd  = acc_o;
        end

        sum = st_q.br_even + st_q.br_odd;
        rnd = (sum + HALF_LSB) >>> (CW - 1);
        st_d.s2_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            if (rnd > MAXV) begin
                st_d.result = MAXV[DW-1:0];
            end else if (rnd < MINV) begin
                st_d.result = MINV[DW-1:0];
            end else begin
                st_d.result = rnd[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.s2_valid;
    assign res_data  = st_q.result;

endmodule

// File: rtl/dwt_band_seq.sv
module dwt_band_seq
    import dwt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_valid,
    input  logic signed [DW-1:0] lo_data,
    input  logic                 hi_valid,
    input  logic signed [DW-1:0] hi_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic                 out_band
);
    typedef struct packed {
        logic          out_valid;
        band_e         out_band;
        logic [DW-1:0] out_data;
        logic          hi_pend;
        logic [DW-1:0] hi_hold;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        if (lo_valid) begin
            st_d.out_valid = 1'b1;
            st_d.out_band  = BAND_LO;
            st_d.out_data  = lo_data;
        end else if (st_q.hi_pend) begin
            st_d.out_valid = 1'b1;
            st_d.out_band  = BAND_HI;
            st_d.out_data  = st_q.hi_hold;
            st_d.hi_pend   = 1'b0;
        end
        if (hi_valid) begin
            st_d.hi_pend = 1'b1;
            st_d.hi_hold = hi_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{out_valid: 1'b0, out_band: BAND_LO, out_data: '0,
                      hi_pend: 1'b0, hi_hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
    assign out_band  = st_q.out_band;

endmodule

// File: rtl/dwt_analysis_bank.sv
module dwt_analysis_bank #(
    parameter int                 DW      = 16,
    parameter int                 CW      = 16,
    parameter int                 TAPS    = 4,
    parameter logic [TAPS*CW-1:0] LO_COEF = 64'hEF70_1CB1_6B13_3DD2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic                 flush,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data,
    output logic                 out_band
);
    localparam int HALF = TAPS / 2;

    logic                    pair_valid;
    logic [HALF-1:0][DW-1:0] even_win;
    logic [HALF-1:0][DW-1:0] odd_win;
    logic                    band_valid [2];
    logic signed [DW-1:0]    band_data  [2];
    logic                    lo_valid;

    dwt_pair_front #(.DW(DW), .TAPS(TAPS)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .flush      (flush),
        .pair_valid (pair_valid),
        .even_win   (even_win),
        .odd_win    (odd_win)
    );

    for (genvar b = 0; b < 2; b++) begin : g_band
        dwt_polyphase_mac #(
            .DW(DW), .CW(CW), .TAPS(TAPS), .COEF(LO_COEF), .HIGH(b == 1)
        ) u_mac (
            .clk        (clk),
            .rst_n      (rst_n),
            .pair_valid (pair_valid),
            .even_win   (even_win),
            .odd_win    (odd_win),
            .res_valid  (band_valid[b]),
            .res_data   (band_data[b])
        );
    end

    assign lo_valid = band_valid[0];

    dwt_band_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_valid  (lo_valid),
        .lo_data   (band_data[0]),
        .hi_valid  (band_valid[1]),
        .hi_data   (band_data[1]),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_band  (out_band)
    );

endmodule

// File: rtl/dwt_analysis_bank_chk.sv
module dwt_analysis_bank_chk (
    input logic clk,
    input logic rst_n,
    input logic pair_valid,
    input logic res_valid,
    input logic out_valid,
    input logic out_band
);
    assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_band) |=> (out_valid && out_band));

    assert_hi_has_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_band) |-> $past(out_valid && !out_band));

    assert_lo_follows_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (out_valid && !out_band));

    assert_lo_has_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_band) |-> $past(res_valid));

    assert_pairs_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

endmodule

bind dwt_analysis_bank dwt_analysis_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_valid (pair_valid),
    .res_valid  (lo_valid),
    .out_valid  (out_valid),
    .out_band   (out_band)
);

// File: tb/tb_dwt_analysis_bank.sv
module tb_dwt_analysis_bank;
    localparam int TAPS = 4;
    localparam int H [TAPS] = '{15826, 27411, 7345, -4240};
    localparam int N_TAB = 12;
    localparam int STIM [N_TAB] = '{1000, -2000, 3000, 12000, -32768, 32767,
                                    5, -7, 16384, -16384, 250, 999};
    localparam int GAPS [N_TAB] = '{0, 2, 0, 1, 0, 0, 3, 0, 1, 0, 0, 0};

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, flush = 1'b0;
    logic signed [15:0] in_data = '0;
    logic out_valid, out_band;
    logic signed [15:0] out_data;

    dwt_analysis_bank dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .flush(flush), .out_valid(out_valid), .out_data(out_data), .out_band(out_band)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int cap_d[$], cap_b[$], cap_c[$];
    int src[$], exp_d[$], exp_b[$];

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            cap_d.push_back(int'(out_data));
            cap_b.push_back(int'(out_band));
            cap_c.push_back(cyc);
        end
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int rsat(longint acc);
        longint r;
        r = (acc + 64'sd16384) >>> 15;
        if (r > 32767) return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    function automatic int hi_tap(int j);
        int v;
        v = H[TAPS-1-j];
        return (j % 2 == 1) ? -v : v;
    endfunction

    task automatic model_stream();
        int n, m;
        int xs[$];
        longint alo, ahi;
        n  = src.size();
        m  = n + (n % 2) + TAPS - 2;
        xs = src;
        while (xs.size() < m) xs.push_back(0);
        for (int k = 0; k < m / 2; k++) begin
            alo = 0;
            ahi = 0;
            for (int j = 0; j < TAPS; j++) begin
                int idx;
                idx = 2 * k + 1 - j;
                if (idx >= 0) begin
                    alo += longint'(H[j]) * xs[idx];
                    ahi += longint'(hi_tap(j)) * xs[idx];
                end
            end
            exp_d.push_back(rsat(alo)); exp_b.push_back(0);
            exp_d.push_back(rsat(ahi)); exp_b.push_back(1);
        end
        src.delete();
    endtask

    task automatic send(int x, int gap);
        in_valid = 1'b1;
        in_data  = 16'(x);
        src.push_back(x);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        repeat (12) @(negedge clk);
        model_stream();
    endtask

    task automatic compare(string req);
        int n;
        check(cap_d.size() == exp_d.size(), req, "output count", cap_d.size(), exp_d.size());
        n = (cap_d.size() < exp_d.size()) ? cap_d.size() : exp_d.size();
        for (int i = 0; i < n; i++) begin
            check(cap_b[i] == exp_b[i], req, $sformatf("band of word %0d", i), cap_b[i], exp_b[i]);
            check(cap_d[i] == exp_d[i], req, $sformatf("value of word %0d", i), cap_d[i], exp_d[i]);
        end
    endtask

    task automatic clear_all();
        cap_d.delete(); cap_b.delete(); cap_c.delete();
        exp_d.delete(); exp_b.delete(); src.delete();
    endtask

    initial begin
        int c1;
        bit seen_max, seen_min;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_data == 16'sd0, "R1", "out_data in reset", int'(out_data), 0);
        check(out_band == 1'b0, "R1", "out_band in reset", int'(out_band), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);

        // R2 R3 R4 R5 R6 R8: table walked back to back, then flushed
        c1 = 0;
        for (int i = 0; i < N_TAB; i++) begin
            if (i == 1) c1 = cyc;
            send(STIM[i], 0);
        end
        do_flush();
        compare("R2/R3/R4/R8 continuous");
        if (cap_c.size() >= 12) begin
            check(cap_c[0] == c1 + 4, "R5", "low-pass latency", cap_c[0] - c1, 4);
            check(cap_c[1] == c1 + 5, "R5", "high-pass latency", cap_c[1] - c1, 5);
            check(cap_c[11] - cap_c[0] == 11, "R6", "span of 12 steady outputs", cap_c[11] - cap_c[0], 11);
        end else begin
            check(1'b0, "R5", "too few outputs for timing", cap_c.size(), 12);
        end
        clear_all();

        // R10 R8: odd-length stream with idle gaps
        for (int i = 0; i < 7; i++) send(STIM[i], GAPS[i]);
        do_flush();
        compare("R10/R8 gapped odd");
        clear_all();

        // R7: saturation at both rails
        for (int i = 0; i < 6; i++) send(32767, 0);
        for (int i = 0; i < 6; i++) send(-32768, 0);
        do_flush();
        compare("R7 saturation");
        seen_max = 1'b0;
        seen_min = 1'b0;
        for (int i = 0; i < cap_d.size(); i++) begin
            if (cap_b[i] == 0 && cap_d[i] == 32767) seen_max = 1'b1;
            if (cap_b[i] == 0 && cap_d[i] == -32768) seen_min = 1'b1;
        end
        check(seen_max, "R7", "positive rail reached", int'(seen_max), 1);
        check(seen_min, "R7", "negative rail reached", int'(seen_min), 1);
        clear_all();

        // R7: rounding of small values, single sample
        send(1, 0);
        do_flush();
        compare("R7 rounding");
        clear_all();

        // R9 R8: samples offered during flush drain are dropped, history cleared
        for (int i = 0; i < 4; i++) send(STIM[i + 2], 0);
        model_stream();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        in_valid = 1'b1;
        in_data  = 16'sd30000;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        repeat (12) @(negedge clk);
        for (int i = 0; i < 4; i++) send(STIM[i + 6], 1);
        do_flush();
        compare("R9/R8 drain and restart");
        clear_all();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule